// File: doc/BRIEF.md
# Bit-Programmable Port With Pattern Interrupt

This block is one general-purpose port whose every line can be set as an input or an output on its own. A direction register chooses the role of each line. A data write loads an output latch, but only in the positions currently set as outputs. A data read returns a merged byte: output positions give the latched value, and input positions give the live pin level with no capture.

The block can raise an interrupt when the merged line pattern meets a programmed condition. A mask register removes chosen lines from the test. A two-bit selector picks one of four reductions over the lines that remain: all high, any high, not all high, or none high. Output positions feed the reduction with their latched value, so a pattern can mix driven and sensed lines. The active-low interrupt line follows the condition in the same cycle and is gated by an enable bit. A mask of all ones is an illegal setting, and the block forces the interrupt inactive while it is held.

Top module: `pbp_port`

## Requirements
- R1: Writing with `dir_we` loads `wdata` into the direction register at the clock edge. A bit of 1 makes that line an output and a bit of 0 makes it an input. `pin_oe` shows the direction register.
- R2: A write with `dat_we` changes only the latch bits whose direction bit is 1. Latch bits in input positions keep their value. `pin_out` shows the whole latch.
- R3: `rd_data` returns the latched bit at output positions and the current `pin_in` bit at input positions. It is combinational and has no input capture.
- R4: `func_we` loads `wdata[1:0]` as the condition code: 0 = every monitored line high, 1 = at least one monitored line high, 2 = not every monitored line high, 3 = no monitored line high.
- R5: `mask_we` loads the mask from `wdata`. A mask bit of 1 drops that line from the condition and a mask bit of 0 keeps it. A dropped line counts as high for codes 0 and 2 and as low for codes 1 and 3.
- R6: While the mask is all ones, `irq_n` stays high whatever the code and the lines.
- R7: Output positions take part in the condition through their latched value. The `pin_in` level at those positions is ignored.
- R8: `irq_n` is active low. It is low exactly when the enable bit is 1 and the condition holds, and it follows a `pin_in` change in the same cycle. `ien_we` loads the enable from `wdata[0]`.
- R9: While `rst_n` is low, every line is an input, the latch is zero, the mask is zero (nothing masked), the code is 0 and the interrupt is disabled.
- R10: If `dir_we` and `dat_we` are both high in one cycle, the data write uses the direction held before that edge, and the new direction takes effect afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| dir_we | input | 1 | Load direction register from wdata |
| mask_we | input | 1 | Load interrupt mask from wdata |
| func_we | input | 1 | Load condition code from wdata[1:0] |
| ien_we | input | 1 | Load interrupt enable from wdata[0] |
| dat_we | input | 1 | Write output latch (output bits only) |
| wdata | input | W | Write data shared by all write strobes |
| rd_data | output | W | Merged read of latch and live pins |
| pin_in | input | W | Pin levels sensed from the pad |
| pin_out | output | W | Output latch driven to the pad |
| pin_oe | output | W | Per-line output enable |
| irq_n | output | 1 | Pattern interrupt, active low |

## Verification
A direction write and a data write can land on the same edge, and the result depends on which direction the latch update sees. The bench raises both strobes together with opposite direction values and reads back `pin_out` and `rd_data`. A per-cycle reference model, which applies the old direction to the data and then loads the new one, judges the result. The bench also changes `pin_in` in the same cycles as configuration writes, so the combinational interrupt path and the register updates are compared against each other every cycle.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
   typedef enum logic [1:0] {
      FN_ALL  = 2'd0,
      FN_ANY  = 2'd1,
      FN_NALL = 2'd2,
      FN_NANY = 2'd3
   } pbp_fn_e;
endpackage

// File: rtl/pbp_lat.sv
module pbp_lat #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dir_we,
   input  logic         dat_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] lat_q,
   output logic [W-1:0] lines
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir_q[i] <= 1'b0;
            lat_q[i] <= 1'b0;
         end else begin
            if (dir_we) dir_q[i] <= wdata[i];
            if (dat_we && dir_q[i]) lat_q[i] <= wdata[i];
         end
      end
      assign lines[i] = dir_q[i] ? lat_q[i] : pin_in[i];
   end
endmodule

// File: rtl/pbp_cfg.sv
module pbp_cfg
   import pbp_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mask_we,
   input  logic         func_we,
   input  logic         ien_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_q,
   output pbp_fn_e      fn_q,
   output logic         ien_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         fn_q   <= FN_ALL;
         ien_q  <= 1'b0;
      end else begin
         if (mask_we) mask_q <= wdata;
         if (func_we) fn_q   <= pbp_fn_e'(wdata[1:0]);
         if (ien_we)  ien_q  <= wdata[0];
      end
   end
endmodule

// File: rtl/pbp_match.sv
module pbp_match
   import pbp_pkg::*;
#(
   parameter int W       = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lines,
   input  logic [W-1:0] mask_q,
   input  pbp_fn_e      fn_q,
   input  logic         ien_q,
   output logic         irq_n
);
   logic all_hi;
   logic any_hi;
   logic illegal;
   logic hit;
   logic fire;

   assign all_hi  = &(lines | mask_q);
   assign any_hi  = |(lines & ~mask_q);
   assign illegal = &mask_q;

   always_comb begin
      unique case (fn_q)
         FN_ALL:  hit = all_hi;
         FN_ANY:  hit = any_hi;
         FN_NALL: hit = ~all_hi;
         FN_NANY: hit = ~any_hi;
         default: hit = 1'b0;
      endcase
   end

   assign fire = ien_q & hit & ~illegal;

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n <= 1'b1;
         else        irq_n <= ~fire;
      end
   end else begin : g_comb
      assign irq_n = ~fire;
   end
endmodule

// File: rtl/pbp_port.sv
module pbp_port
   import pbp_pkg::*;
#(
   parameter int W       = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dir_we,
   input  logic         mask_we,
   input  logic         func_we,
   input  logic         ien_we,
   input  logic         dat_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rd_data,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic         irq_n
);
   if (W < 2) begin : g_bad_w
      $error("pbp_port: W must be at least 2");
   end

   logic [W-1:0] dir_q;
   logic [W-1:0] lat_q;
   logic [W-1:0] lines;
   logic [W-1:0] mask_q;
   pbp_fn_e      fn_q;
   logic         ien_q;

   pbp_lat #(.W(W)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .dir_we (dir_we),
      .dat_we (dat_we),
      .wdata  (wdata),
      .pin_in (pin_in),
      .dir_q  (dir_q),
      .lat_q  (lat_q),
      .lines  (lines)
   );

   pbp_cfg #(.W(W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (mask_we),
      .func_we (func_we),
      .ien_we  (ien_we),
      .wdata   (wdata),
      .mask_q  (mask_q),
      .fn_q    (fn_q),
      .ien_q   (ien_q)
   );

   pbp_match #(.W(W), .IRQ_REG(IRQ_REG)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .lines  (lines),
      .mask_q (mask_q),
      .fn_q   (fn_q),
      .ien_q  (ien_q),
      .irq_n  (irq_n)
   );

   assign rd_data = lines;
   assign pin_out = lat_q;
   assign pin_oe  = dir_q;
endmodule

// File: rtl/pbp_port_chk.sv
module pbp_port_chk #(
   parameter int W       = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         dir_we,
   input logic         dat_we,
   input logic [W-1:0] wdata,
   input logic [W-1:0] rd_data,
   input logic [W-1:0] pin_in,
   input logic [W-1:0] pin_out,
   input logic [W-1:0] pin_oe,
   input logic         irq_n,
   input logic [W-1:0] mask_q,
   input logic         ien_q
);
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_we |=> $stable(pin_oe)); // R1

   AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      dir_we |=> (pin_oe == $past(wdata))); // R1

   AST_IN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      dat_we |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0)); // R2

   AST_OUT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      dat_we |=> (((pin_out ^ $past(wdata)) & $past(pin_oe)) == '0)); // R10

   AST_RD_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (rd_data == ((pin_out & pin_oe) | (pin_in & ~pin_oe)))); // R3

   AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (IRQ_REG == 1'b0 && (&mask_q)) |-> irq_n); // R6

   AST_IEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (IRQ_REG == 1'b0 && !ien_q) |-> irq_n); // R8
endmodule

bind pbp_port pbp_port_chk #(.W(W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .dir_we  (dir_we),
   .dat_we  (dat_we),
   .wdata   (wdata),
   .rd_data (rd_data),
   .pin_in  (pin_in),
   .pin_out (pin_out),
   .pin_oe  (pin_oe),
   .irq_n   (irq_n),
   .mask_q  (mask_q),
   .ien_q   (ien_q)
);

// File: tb/sim_pbp_port.sv
`timescale 1ns/1ps
module sim_pbp_port;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dir_we = 1'b0, mask_we = 1'b0, func_we = 1'b0;
   logic         ien_we = 1'b0, dat_we = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] rd_data, pin_out, pin_oe;
   logic         irq_n;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic [W-1:0] m_dir = '0, m_lat = '0, m_mask = '0;
   int           m_fn = 0;
   logic         m_ien = 1'b0;
   logic [15:0]  lfsr = 16'hACE1;

   always #2 clk = ~clk;

   pbp_port #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .dir_we(dir_we), .mask_we(mask_we),
      .func_we(func_we), .ien_we(ien_we), .dat_we(dat_we), .wdata(wdata),
      .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq_n(irq_n)
   );

   function automatic logic exp_irq_n();
      int mon = 0;
      int ones = 0;
      logic cond;
      for (int b = 0; b < W; b++) begin
         logic v;
         v = m_dir[b] ? m_lat[b] : pin_in[b];
         if (!m_mask[b]) begin
            mon++;
            if (v) ones++;
         end
      end
      if (mon == 0) cond = 1'b0;
      else case (m_fn)
         0: cond = (ones == mon);
         1: cond = (ones > 0);
         2: cond = (ones != mon);
         default: cond = (ones == 0);
      endcase
      return !(m_ien && cond);
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string itag);
      logic [W-1:0] erd;
      for (int b = 0; b < W; b++) erd[b] = m_dir[b] ? m_lat[b] : pin_in[b];
      chk("R1 pin_oe", pin_oe, m_dir);
      chk("R2 pin_out", pin_out, m_lat);
      chk("R3 rd_data", rd_data, erd);
      chk(itag, {{(W-1){1'b0}}, irq_n}, {{(W-1){1'b0}}, exp_irq_n()});
   endtask

   task automatic cyc(input logic dw, input logic mw, input logic fw, input logic iw,
                      input logic tw, input logic [W-1:0] wd, input logic [W-1:0] pin,
                      input string itag);
      dir_we = dw; mask_we = mw; func_we = fw; ien_we = iw; dat_we = tw;
      wdata = wd; pin_in = pin;
      @(negedge clk);
      compare_all(itag);
      @(posedge clk);
      // model update: data write uses direction before the edge (R10)
      if (tw) for (int b = 0; b < W; b++) if (m_dir[b]) m_lat[b] = wd[b];
      if (dw) m_dir = wd;
      if (mw) m_mask = wd;
      if (fw) m_fn = int'(wd[1:0]);
      if (iw) m_ien = wd[0];
      #1;
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R9: state held under reset
      pin_in = 8'h3C;
      @(negedge clk);
      compare_all("R9 irq_n in reset");
      chk("R9 pin_oe in reset", pin_oe, 8'h00);
      @(posedge clk); #1;
      rst_n = 1'b1;

      cyc(0,0,0,0,0, 8'h00, 8'h5A, "R9 irq_n after reset");
      cyc(0,0,0,1,0, 8'h01, 8'hFF, "R8 enable");
      cyc(0,0,0,0,0, 8'h00, 8'hFF, "R8 AND all high");
      cyc(0,0,0,0,0, 8'h00, 8'hFE, "R8 AND one low");
      // R1 / R2: upper lines out, write hits only them
      cyc(1,0,0,0,0, 8'hF0, 8'h00, "R1 dir write");
      cyc(0,0,0,0,1, 8'hA5, 8'h0F, "R2 data write");
      cyc(0,0,0,0,0, 8'h00, 8'h0F, "R7 outputs in condition");
      // R10: same-cycle direction and data write
      cyc(1,0,0,0,1, 8'h0F, 8'h33, "R10 collision");
      cyc(0,0,0,0,0, 8'h00, 8'h33, "R10 after collision");
      cyc(0,0,0,0,1, 8'hC3, 8'hFF, "R10 new dir write");
      // R7: all outputs latched high, pins low
      cyc(1,0,0,0,0, 8'hFF, 8'h00, "R7 set all out");
      cyc(0,0,0,0,1, 8'hFF, 8'h00, "R7 latch ones");
      cyc(0,0,0,0,0, 8'h00, 8'h00, "R7 pins ignored");
      cyc(1,0,0,0,0, 8'h00, 8'h00, "R7 back to input");
      // R4 / R5: each code with a mask
      cyc(0,1,0,0,0, 8'h0F, 8'hF0, "R5 mask low nibble");
      cyc(0,0,0,0,0, 8'h00, 8'hF0, "R5 AND masked as one");
      cyc(0,0,1,0,0, 8'h01, 8'h0F, "R4 code OR");
      cyc(0,0,0,0,0, 8'h00, 8'h0F, "R5 OR masked as zero");
      cyc(0,0,0,0,0, 8'h00, 8'h1F, "R4 OR one high");
      cyc(0,0,1,0,0, 8'h02, 8'hF0, "R4 code NAND");
      cyc(0,0,0,0,0, 8'h00, 8'hE0, "R4 NAND one low");
      cyc(0,0,1,0,0, 8'h03, 8'h0F, "R4 code NOR");
      cyc(0,0,0,0,0, 8'h00, 8'h8F, "R4 NOR one high");
      // R6: full mask
      cyc(0,1,0,0,0, 8'hFF, 8'h00, "R6 full mask");
      cyc(0,0,0,0,0, 8'h00, 8'h00, "R6 NOR all low masked");
      cyc(0,0,1,0,0, 8'h02, 8'h55, "R6 NAND masked");
      cyc(0,0,0,0,0, 8'h00, 8'hAA, "R6 hold");
      cyc(0,0,0,1,0, 8'h00, 8'h00, "R8 disable");
      cyc(0,1,1,0,0, 8'h00, 8'h00, "R8 disabled stays high");

      // mixed pseudo-random traffic
      for (int k = 0; k < 600; k++) begin
         logic [15:0] r;
         for (int s = 0; s < 16; s++) lfsr = {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]};
         r = lfsr;
         cyc(r[15:13] == 3'd0, r[12:10] == 3'd0, r[9:8] == 2'd0, r[7:5] == 3'd0,
             r[4], r[7:0] ^ r[15:8], r[11:4], "R4 R5 R6 R8 mixed");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule